// File: doc/BRIEF.md
# RGB to YCbCr Color Converter

This block converts a stream of 8-bit RGB pixels into luma and two chroma components with a three-stage pipeline. For each output channel it forms three signed products of the input components with a programmable coefficient row, adds them, scales the sum down by the fixed-point fraction, adds an unsigned per-channel offset and saturates the result to the 8-bit range. A bypass mode sends the RGB input through unchanged with the same latency, and bypass is the state after reset.

Configuration is double-buffered. Two write strobes load a pending set: one strobe for the mode bit and one for the coefficient matrix with its offsets. The pending set becomes active only on a frame-start strobe, so the pixels of one frame are all processed with one matrix and one mode. Pixels already in the pipeline when the active set changes finish with the set they entered with. A small sideband field travels alongside each pixel and comes out with it.

Top module: `ycc_convert`

## Requirements
- R1: While reset is low and after its release, out_valid is 0 until valid pixels arrive, and both the pending and the active set hold bypass mode and the default matrix, so pixels that arrive before any configuration leave unchanged.
- R2: In bypass mode out_c0, out_c1 and out_c2 equal the R, G and B inputs of the same pixel.
- R3: out_valid equals in_valid delayed by exactly 3 clock cycles in both modes, including with gaps between valid pixels.
- R4: out_user equals the in_user value of the pixel that is presented on the outputs.
- R5: In conversion mode, output channel k equals clamp(floor((m_k0*R + m_k1*G + m_k2*B) / 256) + off_k). The division by 256 is an arithmetic right shift by 8.
- R6: Coefficient m_kc is the 11-bit two's-complement field cfg_coef[(3k+c)*11 +: 11], with c = 0 for R, 1 for G and 2 for B. Offset off_k is the unsigned field cfg_offs[8k +: 8]. Channel 0 is Y, channel 1 is Cb and channel 2 is Cr.
- R7: After reset, the default matrix is Y = (76, 150, 29) with offset 0, Cb = (-43, -84, 128) with offset 128 and Cr = (128, -107, -20) with offset 128.
- R8: Results below 0 come out as 0 and results above 255 come out as 255.
- R9: A cfg_mode_wr strobe (cfg_csc_en = 1 selects conversion, 0 selects bypass) or a cfg_mat_wr strobe changes only the pending set. Pixels that enter before the next frame_start still use the previous active set.
- R10: The pixel that enters in the same cycle as frame_start, and every later pixel, use the newly activated set. Pixels that entered earlier complete with their own mode and matrix, even when they are issued back to back.
- R11: When a configuration write and frame_start fall in the same cycle, the set that becomes active is the one that was pending before that cycle. The newly written values stay pending until the next frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_wr | input | 1 | Loads cfg_csc_en into the pending set |
| cfg_csc_en | input | 1 | Mode bit: 1 selects conversion, 0 selects bypass |
| cfg_mat_wr | input | 1 | Loads cfg_coef and cfg_offs into the pending set |
| cfg_coef | input | 99 | Nine 11-bit signed coefficients, row-major |
| cfg_offs | input | 24 | Three 8-bit unsigned output offsets |
| frame_start | input | 1 | Copies the pending set into the active set |
| in_valid | input | 1 | Input pixel valid |
| in_user | input | 2 | Sideband bits carried with the pixel |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| out_valid | output | 1 | Output pixel valid |
| out_user | output | 2 | Sideband bits of the output pixel |
| out_c0 | output | 8 | Y, or R in bypass mode |
| out_c1 | output | 8 | Cb, or G in bypass mode |
| out_c2 | output | 8 | Cr, or B in bypass mode |

## Verification
The embedded properties assume that in_valid, in_user, the pixel components and frame_start are driven to known values from the first clock edge after reset. The latency and pass-through checks compare against input history from that point. The clamp properties assume that offsets are non-negative, which the unsigned offset field guarantees. The stimulus holds every input at a defined level through reset and updates inputs only on the falling clock edge. It sweeps a 16-level grid of each color component under the default matrix, under saturating matrices and under matrices that select a single component per channel. It places configuration writes and frame starts both inside back-to-back streams and in the same cycle as each other.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

  localparam int unsigned NCH = 3;

  // Full-range standard-definition matrix, integer weights with 8 fraction bits.
  function automatic int bt601_coef(input int row, input int col);
    int v;
    case (row * 3 + col)
      0:       v = 76;
      1:       v = 150;
      2:       v = 29;
      3:       v = -43;
      4:       v = -84;
      5:       v = 128;
      6:       v = 128;
      7:       v = -107;
      8:       v = -20;
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic int bt601_offs(input int ch);
    return (ch == 0) ? 0 : 128;
  endfunction

endpackage

// File: rtl/ycc_cfg_bank.sv
module ycc_cfg_bank #(
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_mode_wr,
  input  logic                        cfg_csc_en,
  input  logic                        cfg_mat_wr,
  input  logic [9*CW-1:0]             cfg_coef,
  input  logic [ycc_pkg::NCH*DW-1:0]  cfg_offs,
  input  logic                        frame_start,
  output logic [9*CW-1:0]             eff_coef,
  output logic [ycc_pkg::NCH*DW-1:0]  eff_offs,
  output logic                        eff_bypass
);
  import ycc_pkg::*;

  localparam int unsigned MW = 9 * CW;
  localparam int unsigned OW = NCH * DW;

  function automatic logic [MW-1:0] dflt_coef();
    logic [MW-1:0] v;
    v = '0;
    for (int i = 0; i < 9; i++) v[i*CW +: CW] = CW'(bt601_coef(i / 3, i % 3));
    return v;
  endfunction

  function automatic logic [OW-1:0] dflt_offs();
    logic [OW-1:0] v;
    v = '0;
    for (int i = 0; i < int'(NCH); i++) v[i*DW +: DW] = DW'(bt601_offs(i));
    return v;
  endfunction

  localparam logic [MW-1:0] DFLT_COEF = dflt_coef();
  localparam logic [OW-1:0] DFLT_OFFS = dflt_offs();

  logic [MW-1:0] pend_coef_q, pend_coef_d, act_coef_q, act_coef_d;
  logic [OW-1:0] pend_offs_q, pend_offs_d, act_offs_q, act_offs_d;
  logic          pend_byp_q,  pend_byp_d,  act_byp_q,  act_byp_d;

  // next state: writes land in the pending set, frame start promotes it
  always_comb begin
    pend_coef_d = cfg_mat_wr  ? cfg_coef    : pend_coef_q;
    pend_offs_d = cfg_mat_wr  ? cfg_offs    : pend_offs_q;
    pend_byp_d  = cfg_mode_wr ? ~cfg_csc_en : pend_byp_q;
    act_coef_d  = frame_start ? pend_coef_q : act_coef_q;
    act_offs_d  = frame_start ? pend_offs_q : act_offs_q;
    act_byp_d   = frame_start ? pend_byp_q  : act_byp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_coef_q <= DFLT_COEF;
      pend_offs_q <= DFLT_OFFS;
      pend_byp_q  <= 1'b1;
      act_coef_q  <= DFLT_COEF;
      act_offs_q  <= DFLT_OFFS;
      act_byp_q   <= 1'b1;
    end else begin
      pend_coef_q <= pend_coef_d;
      pend_offs_q <= pend_offs_d;
      pend_byp_q  <= pend_byp_d;
      act_coef_q  <= act_coef_d;
      act_offs_q  <= act_offs_d;
      act_byp_q   <= act_byp_d;
    end
  end

  // the pixel entering alongside frame_start already sees the promoted set
  assign eff_coef   = act_coef_d;
  assign eff_offs   = act_offs_d;
  assign eff_bypass = act_byp_d;

  // R9: the active set moves only on a frame start
  p_hold_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_coef_q) && $stable(act_offs_q) && $stable(act_byp_q)));

  // R11: a promotion takes what was pending before the write in that cycle
  p_promote_old_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (act_coef_q == $past(pend_coef_q)) && (act_byp_q == $past(pend_byp_q)));

endmodule

// File: rtl/ycc_row.sv
module ycc_row #(
  parameter int unsigned DW   = 8,
  parameter int unsigned CW   = 11,
  parameter int unsigned FRAC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en1,
  input  logic            en2,
  input  logic            en3,
  input  logic [3*CW-1:0] row_coef,
  input  logic [DW-1:0]   row_offs,
  input  logic [3*DW-1:0] pix,
  output logic [DW-1:0]   res
);
  localparam int unsigned PW = DW + CW + 1;
  localparam int unsigned SW = PW + 2;
  localparam int unsigned BW = SW + 1;
  localparam logic signed [BW-1:0] MAXB = BW'((1 << DW) - 1);
  localparam logic signed [SW-1:0] MAXS = SW'((1 << DW) - 1);

  logic signed [PW-1:0] prod_d [3];
  logic signed [PW-1:0] prod_q [3];
  logic [DW-1:0]        offs1_q, offs2_q;
  logic signed [SW-1:0] sum_d, sum_q, shifted;
  logic signed [BW-1:0] biased;
  logic [DW-1:0]        res_d, res_q;

  // stage 1: three signed products
  always_comb begin
    for (int k = 0; k < 3; k++) begin
      prod_d[k] = PW'($signed({1'b0, pix[k*DW +: DW]})) * PW'($signed(row_coef[k*CW +: CW]));
    end
  end

  // stage 2: sum of products
  always_comb begin
    sum_d = SW'(prod_q[0]) + SW'(prod_q[1]) + SW'(prod_q[2]);
  end

  // stage 3: scale, offset, saturate
  always_comb begin
    shifted = sum_q >>> FRAC;
    biased  = BW'(shifted) + BW'($signed({1'b0, offs2_q}));
    if (biased < 0)         res_d = '0;
    else if (biased > MAXB) res_d = '1;
    else                    res_d = biased[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (en1) begin
      for (int k = 0; k < 3; k++) prod_q[k] <= prod_d[k];
      offs1_q <= row_offs;
    end
    if (en2) begin
      sum_q   <= sum_d;
      offs2_q <= offs1_q;
    end
    if (en3) begin
      res_q <= res_d;
    end
  end

  assign res = res_q;

  // R8: a negative sum with zero offset saturates to the bottom
  p_clamp_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en3 && (sum_q < 0) && (offs2_q == '0)) |=> (res == '0));

  // R8: a scaled sum above full scale saturates to the top
  p_clamp_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en3 && ((sum_q >>> FRAC) > MAXS)) |=> (res == '1));

endmodule

// File: rtl/ycc_convert.sv
module ycc_convert #(
  parameter int unsigned DW   = 8,
  parameter int unsigned CW   = 11,
  parameter int unsigned FRAC = 8,
  parameter int unsigned SBW  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_mode_wr,
  input  logic               cfg_csc_en,
  input  logic               cfg_mat_wr,
  input  logic [9*CW-1:0]    cfg_coef,
  input  logic [3*DW-1:0]    cfg_offs,
  input  logic               frame_start,
  input  logic               in_valid,
  input  logic [SBW-1:0]     in_user,
  input  logic [DW-1:0]      in_r,
  input  logic [DW-1:0]      in_g,
  input  logic [DW-1:0]      in_b,
  output logic               out_valid,
  output logic [SBW-1:0]     out_user,
  output logic [DW-1:0]      out_c0,
  output logic [DW-1:0]      out_c1,
  output logic [DW-1:0]      out_c2
);
  import ycc_pkg::*;

  localparam int unsigned LAT = 3;
  localparam int unsigned PXW = NCH * DW;

  logic [9*CW-1:0] eff_coef;
  logic [PXW-1:0]  eff_offs;
  logic            eff_bypass;
  logic [PXW-1:0]  pix_in;
  logic [DW-1:0]   conv [NCH];

  logic [LAT-1:0]  v_q, v_d;
  logic [LAT-1:0]  byp_q;
  logic [SBW-1:0]  user_q [LAT];
  logic [PXW-1:0]  raw_q  [LAT];

  assign pix_in = {in_b, in_g, in_r};

  ycc_cfg_bank #(.DW(DW), .CW(CW)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode_wr (cfg_mode_wr),
    .cfg_csc_en  (cfg_csc_en),
    .cfg_mat_wr  (cfg_mat_wr),
    .cfg_coef    (cfg_coef),
    .cfg_offs    (cfg_offs),
    .frame_start (frame_start),
    .eff_coef    (eff_coef),
    .eff_offs    (eff_offs),
    .eff_bypass  (eff_bypass)
  );

  for (genvar ch = 0; ch < int'(NCH); ch++) begin : g_row
    ycc_row #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .en1      (in_valid),
      .en2      (v_q[0]),
      .en3      (v_q[1]),
      .row_coef (eff_coef[ch*3*CW +: 3*CW]),
      .row_offs (eff_offs[ch*DW +: DW]),
      .pix      (pix_in),
      .res      (conv[ch])
    );
  end

  // valid shift chain
  always_comb begin
    v_d = {v_q[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  // per-pixel side data, moved only where a pixel is present
  always_ff @(posedge clk) begin
    if (in_valid) begin
      user_q[0] <= in_user;
      byp_q[0]  <= eff_bypass;
      raw_q[0]  <= pix_in;
    end
    for (int s = 1; s < int'(LAT); s++) begin
      if (v_q[s-1]) begin
        user_q[s] <= user_q[s-1];
        byp_q[s]  <= byp_q[s-1];
        raw_q[s]  <= raw_q[s-1];
      end
    end
  end

  assign out_valid = v_q[LAT-1];
  assign out_user  = user_q[LAT-1];
  assign out_c0    = byp_q[LAT-1] ? raw_q[LAT-1][0*DW +: DW] : conv[0];
  assign out_c1    = byp_q[LAT-1] ? raw_q[LAT-1][1*DW +: DW] : conv[1];
  assign out_c2    = byp_q[LAT-1] ? raw_q[LAT-1][2*DW +: DW] : conv[2];

  // cycles since reset, so that history checks look only at driven inputs
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_valid_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_user_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm_q == 2'd3) && out_valid) |-> (out_user == $past(in_user, 3)));

  p_bypass_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm_q == 2'd3) && out_valid && $past(eff_bypass, 3)) |->
      ((out_c0 == $past(in_r, 3)) && (out_c1 == $past(in_g, 3)) && (out_c2 == $past(in_b, 3))));

endmodule

// File: tb/ycc_convert_bench.sv
module ycc_convert_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_mode_wr, cfg_csc_en, cfg_mat_wr, frame_start;
  logic [98:0] cfg_coef;
  logic [23:0] cfg_offs;
  logic        in_valid;
  logic [1:0]  in_user;
  logic [7:0]  in_r, in_g, in_b;
  logic        out_valid;
  logic [1:0]  out_user;
  logic [7:0]  out_c0, out_c1, out_c2;

  ycc_convert u_ycc_convert (
    .clk(clk), .rst_n(rst_n),
    .cfg_mode_wr(cfg_mode_wr), .cfg_csc_en(cfg_csc_en),
    .cfg_mat_wr(cfg_mat_wr), .cfg_coef(cfg_coef), .cfg_offs(cfg_offs),
    .frame_start(frame_start),
    .in_valid(in_valid), .in_user(in_user),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_user(out_user),
    .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  int ucnt  = 0;

  // configuration the next write will carry
  int nc [9];
  int no [3];
  bit ncsc;

  // model of pending and active sets
  int pend_c [9];
  int pend_o [3];
  bit pend_csc;
  int act_c [9];
  int act_o [3];
  bit act_csc;

  // expected output stream
  bit    qv [$];
  int    qu [$];
  int    q0 [$];
  int    q1 [$];
  int    q2 [$];
  string qt [$];

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_ch(input int ch, input int r, input int g, input int b);
    int s;
    int t;
    if (!act_csc) return (ch == 0) ? r : (ch == 1) ? g : b;
    s = act_c[ch*3] * r + act_c[ch*3+1] * g + act_c[ch*3+2] * b;
    t = (s >>> 8) + act_o[ch];
    if (t < 0) t = 0;
    if (t > 255) t = 255;
    return t;
  endfunction

  task automatic check_out();
    bit    ev;
    int    eu, e0, e1, e2;
    string et;
    if (qv.size() == 3) begin
      ev = qv.pop_front(); eu = qu.pop_front();
      e0 = q0.pop_front(); e1 = q1.pop_front(); e2 = q2.pop_front();
      et = qt.pop_front();
      chk("R3 out_valid", int'(out_valid), int'(ev));
      if (ev && out_valid) begin
        chk("R4 out_user", int'(out_user), eu);
        chk({et, " out_c0"}, int'(out_c0), e0);
        chk({et, " out_c1"}, int'(out_c1), e1);
        chk({et, " out_c2"}, int'(out_c2), e2);
      end
    end
  endtask

  task automatic push_rec(input bit v, input int u, input int a, input int b2, input int c, input string t);
    qv.push_back(v); qu.push_back(u); q0.push_back(a); q1.push_back(b2); q2.push_back(c); qt.push_back(t);
  endtask

  task automatic tick(input bit v, input int r, input int g, input int b,
                      input bit fs, input bit mw, input bit xw, input string tag);
    int u;
    @(negedge clk);
    check_out();
    u = (r ^ (g >> 2) ^ ucnt) & 3;
    ucnt++;
    in_valid    = v;
    in_r        = r[7:0];
    in_g        = g[7:0];
    in_b        = b[7:0];
    in_user     = u[1:0];
    frame_start = fs;
    cfg_mode_wr = mw;
    cfg_csc_en  = ncsc;
    cfg_mat_wr  = xw;
    for (int i = 0; i < 9; i++) cfg_coef[i*11 +: 11] = 11'(nc[i]);
    for (int i = 0; i < 3; i++) cfg_offs[i*8 +: 8] = 8'(no[i]);
    if (fs) begin
      act_c = pend_c; act_o = pend_o; act_csc = pend_csc;
    end
    if (mw) pend_csc = ncsc;
    if (xw) begin
      pend_c = nc; pend_o = no;
    end
    if (v) push_rec(1'b1, u, model_ch(0, r, g, b), model_ch(1, r, g, b), model_ch(2, r, g, b), tag);
    else   push_rec(1'b0, 0, 0, 0, 0, tag);
  endtask

  task automatic sweep(input bit fs_first, input string tag);
    int n;
    n = 0;
    for (int ri = 0; ri < 16; ri++)
      for (int gi = 0; gi < 16; gi++)
        for (int bi = 0; bi < 16; bi++) begin
          tick(1'b1, ri * 17, gi * 17, bi * 17, fs_first && (n == 0), 1'b0, 1'b0, tag);
          n++;
          if ((n % 5) == 0) tick(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0, tag);
        end
  endtask

  task automatic drain();
    repeat (4) tick(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0, "R3");
  endtask

  task automatic set_nc(input int c0, input int c1, input int c2, input int c3, input int c4,
                        input int c5, input int c6, input int c7, input int c8,
                        input int o0, input int o1, input int o2);
    nc[0] = c0; nc[1] = c1; nc[2] = c2; nc[3] = c3; nc[4] = c4;
    nc[5] = c5; nc[6] = c6; nc[7] = c7; nc[8] = c8;
    no[0] = o0; no[1] = o1; no[2] = o2;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_user = 0; in_r = 0; in_g = 0; in_b = 0;
    frame_start = 0; cfg_mode_wr = 0; cfg_csc_en = 0; cfg_mat_wr = 0;
    cfg_coef = '0; cfg_offs = '0;
    ncsc = 0;
    // model reset state, R1 and R7: bypass with the default matrix
    set_nc(76, 150, 29, -43, -84, 128, 128, -107, -20, 0, 128, 128);
    pend_c = nc; pend_o = no; pend_csc = 0;
    act_c = nc;  act_o = no;  act_csc = 0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) push_rec(1'b0, 0, 0, 0, 0, "R1");

    // R1: no configuration yet, pixels pass unchanged
    for (int i = 0; i < 64; i++) tick(1'b1, i * 4, 255 - i, i * 3, 1'b0, 1'b0, 1'b0, "R1");
    drain();

    // R9: mode write alone does not change the stream before a frame start
    ncsc = 1;
    tick(1'b1, 10, 20, 30, 1'b0, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 6; i++) tick(1'b1, 200 - i, i, 77, 1'b0, 1'b0, 1'b0, "R9");
    // R7: default matrix after promotion
    sweep(1'b1, "R7");
    drain();

    // R9: matrix write in mid-stream, older matrix stays in use
    set_nc(1023, 1023, 1023, -1024, -1024, -1024, -1024, 1023, 0, 255, 0, 128);
    tick(1'b1, 100, 50, 25, 1'b0, 1'b0, 1'b1, "R9");
    for (int i = 0; i < 6; i++) tick(1'b1, 9 * i, 250, 3, 1'b0, 1'b0, 1'b0, "R9");
    // R8: saturating matrix
    sweep(1'b1, "R8");
    drain();

    // R6: single-tap rows expose field positions and offset positions
    set_nc(0, 0, 256, 256, 0, 0, 0, 256, 0, 0, 7, 19);
    tick(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b1, "R6");
    sweep(1'b1, "R6");
    drain();

    // R5: mixed-sign general matrix
    set_nc(100, -30, 60, -200, 300, -5, 17, -1, 511, 10, 128, 3);
    tick(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b1, "R5");
    sweep(1'b1, "R5");
    drain();

    // R11: write and frame start in one cycle
    set_nc(1023, 1023, 1023, -1024, -1024, -1024, -1024, 1023, 0, 255, 0, 128);
    tick(1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b1, "R11");
    set_nc(0, 0, 256, 256, 0, 0, 0, 256, 0, 0, 7, 19);
    tick(1'b1, 40, 90, 140, 1'b1, 1'b0, 1'b1, "R11");
    for (int i = 0; i < 20; i++) tick(1'b1, 12 * i, 240 - 11 * i, 5 * i, 1'b0, 1'b0, 1'b0, "R11");
    tick(1'b1, 40, 90, 140, 1'b1, 1'b0, 1'b0, "R11");
    for (int i = 0; i < 20; i++) tick(1'b1, 12 * i, 240 - 11 * i, 5 * i, 1'b0, 1'b0, 1'b0, "R11");

    // R10: back-to-back stream across a mode change to bypass
    ncsc = 0;
    tick(1'b1, 1, 2, 3, 1'b0, 1'b1, 1'b0, "R10");
    for (int i = 0; i < 5; i++) tick(1'b1, 60 + i, 61 + i, 62 + i, 1'b0, 1'b0, 1'b0, "R10");
    tick(1'b1, 201, 102, 33, 1'b1, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 20; i++) tick(1'b1, 13 * i, 255 - 7 * i, 128, 1'b0, 1'b0, 1'b0, "R2");
    drain();

    done = 1;
    summary();
    $finish;
  end

endmodule